// File: doc/BRIEF.md
# Serial Receive Path with Start-Bit Validation

This block is the receive side of a classic asynchronous serial port. It is clocked by the system clock and advanced by a one-cycle enable that pulses sixteen times per bit period. The raw line input first passes through a resynchronizer. While the line is idle, the block watches for a low level. It then waits half a bit time and confirms that the line is still low at the centre of the start bit. If the line has gone high again, it drops the event as noise.

Once a start bit is confirmed, the block samples each data bit, the optional parity bit and the first stop bit at the centre of its bit period. It places the character in a one-byte holding register and updates five status indications: character available, overrun, parity error, framing error and line break.

The frame shape comes from four static configuration inputs: word length, parity enable, parity sense and fixed parity. These are the same settings the companion transmitter uses. A one-cycle read strobe on the holding register removes the character-available indication. A second read strobe, on the status, clears the four error indications.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_avail`, `err_overrun`, `err_parity`, `err_frame` and `brk_seen` are all 0.
- R2: A low level seen on a tick while idle is confirmed only if the line is still low on the 8th tick after it. If the line is high at that point, nothing is stored and no flag changes.
- R3: Data bits are received least significant bit first. The count comes from `cfg_len` (0→5, 1→6, 2→7, 3→8 bits). `rx_byte` holds the bits with all unused upper bits 0, and `rx_avail` becomes 1 when a character is stored.
- R4: With `cfg_par_on`=1 and `cfg_par_fix`=0, the parity bit is expected to make the count of ones over data plus parity even when `cfg_par_even`=1, and odd when it is 0. A mismatch sets `err_parity`.
- R5: With `cfg_par_on`=1 and `cfg_par_fix`=1, the parity bit is expected to be 1 when `cfg_par_even`=0 and 0 when `cfg_par_even`=1. A mismatch sets `err_parity`.
- R6: A stop bit sampled low sets `err_frame`, unless the whole frame was low.
- R7: A frame whose start, data, parity and stop samples are all 0 sets `brk_seen`, stores 0x00 and sets `rx_avail`. It sets neither `err_frame` nor `err_parity`.
- R8: After a stop bit sampled low, no new start is accepted until the line has been seen high.
- R9: A character that completes while `rx_avail` is 1 (and is not being read in that cycle) is discarded. `err_overrun` is set and `rx_byte` keeps the unread character.
- R10: A pulse on `rd_data` clears `rx_avail` in the next cycle, unless a character completes in the same cycle.
- R11: A pulse on `rd_status` clears the four error flags. A flag being set by a character completing in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Word length code, 5 + value bits |
| cfg_par_on | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Parity sense |
| cfg_par_fix | input | 1 | Fixed parity value |
| rd_data | input | 1 | Holding-register read strobe |
| rd_status | input | 1 | Status read strobe |
| rx_byte | output | 8 | Received character |
| rx_avail | output | 1 | Character available |
| err_overrun | output | 1 | Overrun flag |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| brk_seen | output | 1 | Break flag |

## Verification
A completing character can set an error flag in the very cycle that software reads the status to clear it. To provoke this, the bench holds the status read strobe high through an entire bad-parity frame, so that the collision cannot be missed. It then judges the result by requiring that the parity flag is seen high for exactly one cycle, which shows that the set won over the clear. Random frames with random formats and deliberately wrong parity run alongside directed cases for glitch, break, framing and overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic              done;
        logic [CHAR_W-1:0] data;
        logic              par_bad;
        logic              frm_bad;
        logic              brk;
    } rx_char_t;

    function automatic logic [3:0] word_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_on,
    input  logic       cfg_par_even,
    input  logic       cfg_par_fix,
    output rx_char_t   char_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int MID   = OVERSAMPLE / 2;

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        idx;
        logic [CHAR_W-1:0] shreg;
        logic              par_s;
        logic              allz;
        rx_char_t          out;
    } frame_t;

    frame_t s_d, s_q;
    logic [3:0] nbits;
    logic       exp_par;
    logic       last_tick;

    always_comb begin
        nbits     = word_bits(cfg_len);
        last_tick = (s_q.cnt == CNT_W'(OVERSAMPLE - 1));
        if (cfg_par_fix) exp_par = ~cfg_par_even;
        else             exp_par = cfg_par_even ? ^s_q.shreg : ~^s_q.shreg;

        s_d          = s_q;
        s_d.out.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (tick && !rx) begin
                    s_d.st  = ST_START;
                    s_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (s_q.cnt == CNT_W'(MID - 1)) begin
                        s_d.cnt = '0;
                        if (rx) begin
                            s_d.st = ST_IDLE;
                        end else begin
                            s_d.st    = ST_DATA;
                            s_d.idx   = '0;
                            s_d.shreg = '0;
                            s_d.allz  = 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (last_tick) begin
                        s_d.cnt              = '0;
                        s_d.shreg[s_q.idx]   = rx;
                        s_d.allz             = s_q.allz & ~rx;
                        if ({1'b0, s_q.idx} == nbits - 4'd1)
                            s_d.st = cfg_par_on ? ST_PAR : ST_STOP;
                        else
                            s_d.idx = s_q.idx + 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (last_tick) begin
                        s_d.cnt   = '0;
                        s_d.par_s = rx;
                        s_d.allz  = s_q.allz & ~rx;
                        s_d.st    = ST_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (last_tick) begin
                        s_d.cnt         = '0;
                        s_d.out.done    = 1'b1;
                        s_d.out.brk     = s_q.allz & ~rx;
                        s_d.out.frm_bad = ~rx & ~(s_q.allz & ~rx);
                        s_d.out.par_bad = cfg_par_on & ~(s_q.allz & ~rx)
                                        & (s_q.par_s != exp_par);
                        s_d.out.data    = (s_q.allz & ~rx) ? '0 : s_q.shreg;
                        s_d.st          = rx ? ST_IDLE : ST_WAITHI;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAITHI: begin
                if (rx) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign char_o = s_q.out;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rx_char_t          char_i,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [CHAR_W-1:0] hold_o,
    output logic              avail_o,
    output logic              ovr_o,
    output logic              par_o,
    output logic              frm_o,
    output logic              brk_o
);
    typedef struct packed {
        logic [CHAR_W-1:0] hold;
        logic              avail;
        logic              ovr;
        logic              par;
        logic              frm;
        logic              brk;
    } stat_t;

    stat_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_data) r_d.avail = 1'b0;
        if (rd_status) begin
            r_d.ovr = 1'b0;
            r_d.par = 1'b0;
            r_d.frm = 1'b0;
            r_d.brk = 1'b0;
        end
        if (char_i.done) begin
            if (r_q.avail && !rd_data) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.hold  = char_i.data;
                r_d.avail = 1'b1;
                r_d.par   = r_d.par | char_i.par_bad;
                r_d.frm   = r_d.frm | char_i.frm_bad;
                r_d.brk   = r_d.brk | char_i.brk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold_o  = r_q.hold;
    assign avail_o = r_q.avail;
    assign ovr_o   = r_q.ovr;
    assign par_o   = r_q.par;
    assign frm_o   = r_q.frm;
    assign brk_o   = r_q.brk;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_on,
    input  logic       cfg_par_even,
    input  logic       cfg_par_fix,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] rx_byte,
    output logic       rx_avail,
    output logic       err_overrun,
    output logic       err_parity,
    output logic       err_frame,
    output logic       brk_seen
);
    logic     rx_s;
    rx_char_t frame_char;
    logic     char_done;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    uart_rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .rx          (rx_s),
        .cfg_len     (cfg_len),
        .cfg_par_on  (cfg_par_on),
        .cfg_par_even(cfg_par_even),
        .cfg_par_fix (cfg_par_fix),
        .char_o      (frame_char)
    );

    assign char_done = frame_char.done;

    uart_rx_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_i   (frame_char),
        .rd_data  (rd_data),
        .rd_status(rd_status),
        .hold_o   (rx_byte),
        .avail_o  (rx_avail),
        .ovr_o    (err_overrun),
        .par_o    (err_parity),
        .frm_o    (err_frame),
        .brk_o    (brk_seen)
    );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       char_done,
    input logic       rd_data,
    input logic       rd_status,
    input logic [7:0] rx_byte,
    input logic       rx_avail,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       err_frame,
    input logic       brk_seen
);
    a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> rx_avail && $stable(rx_byte));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !char_done) |=> !rx_avail);

    a_r11_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !char_done) |=> !(err_overrun || err_parity || err_frame || brk_seen));

    a_r7_break_not_framing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_seen) |-> !$rose(err_frame) && !$rose(err_parity));

    a_r3_avail_from_char: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_avail) |-> $past(char_done));

    a_r3_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        !char_done |=> $stable(rx_byte));
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_done  (char_done),
    .rd_data    (rd_data),
    .rd_status  (rd_status),
    .rx_byte    (rx_byte),
    .rx_avail   (rx_avail),
    .err_overrun(err_overrun),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .brk_seen   (brk_seen)
);

// File: tb/uart_rx_core_test.sv
`timescale 1ns/1ps
module uart_rx_core_test;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_on = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_fix = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_avail, err_overrun, err_parity, err_frame, brk_seen;

    int checks = 0;
    int fails  = 0;
    logic [1:0] tdiv = '0;

    uart_rx_core uut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 1'b1;
        tick16 <= (tdiv == 2'd3);
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic par_bit(input logic [7:0] d, input logic even, input logic fix);
        if (fix) return ~even;
        return even ? ^d : ~^d;
    endfunction

    function automatic logic [7:0] mask(input logic [7:0] d, input logic [1:0] len);
        return d & ((8'd1 << (5 + len)) - 8'd1);
    endfunction

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic flip_par, input logic stop);
        logic [7:0] m;
        m = mask(d, cfg_len);
        drive_bit(1'b0);
        for (int i = 0; i < 5 + cfg_len; i++) drive_bit(m[i]);
        if (cfg_par_on) drive_bit(par_bit(m, cfg_par_even, cfg_par_fix) ^ flip_par);
        drive_bit(stop);
        rx_line = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_rd(input logic dat, input logic st);
        rd_data = dat;
        rd_status = st;
        @(negedge clk);
        rd_data = 1'b0;
        rd_status = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        int hi_cnt;
        seed = $urandom(32'h5EED_1234);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 avail", rx_avail, 0);
        chk("R1 flags", {err_overrun, err_parity, err_frame, brk_seen}, 0);

        // R2: glitch shorter than half a bit
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (BITCLK * 12) @(negedge clk);
        chk("R2 glitch no char", rx_avail, 0);
        chk("R2 glitch no flags", {err_overrun, err_parity, err_frame, brk_seen}, 0);
        send(8'hA5, 1'b0, 1'b1);
        chk("R2 after glitch avail", rx_avail, 1);
        chk("R3 byte 8N1", rx_byte, 8'hA5);
        pulse_rd(1'b1, 1'b1);
        chk("R10 read clears avail", rx_avail, 0);

        // R3/R4 random frames
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d;
            logic flip;
            d = 8'($urandom);
            cfg_len = 2'($urandom);
            cfg_par_on = 1'($urandom);
            cfg_par_even = 1'($urandom);
            cfg_par_fix = 1'($urandom) & 1'($urandom);
            flip = cfg_par_on & 1'($urandom);
            @(negedge clk);
            send(d, flip, 1'b1);
            if (mask(d, cfg_len) == 8'h00 && cfg_par_on &&
                (par_bit(8'h00, cfg_par_even, cfg_par_fix) ^ flip) == 1'b0) begin
                // would be all-zero only with stop low; stop is high here
            end
            chk("R3 random avail", rx_avail, 1);
            chk("R3 random byte", rx_byte, mask(d, cfg_len));
            chk(cfg_par_fix ? "R5 random parity" : "R4 random parity", err_parity, flip);
            chk("R6 random no frame err", {err_frame, brk_seen, err_overrun}, 0);
            pulse_rd(1'b1, 1'b1);
        end

        // R5 forced parity directed
        cfg_len = 2'd3; cfg_par_on = 1'b1; cfg_par_fix = 1'b1; cfg_par_even = 1'b0;
        rx_line = 1'b1;
        drive_bit(1'b0); for (int i = 0; i < 8; i++) drive_bit(1'b0);
        drive_bit(1'b1); drive_bit(1'b1);
        chk("R5 fixed one ok", err_parity, 0);
        pulse_rd(1'b1, 1'b1);
        cfg_par_even = 1'b1;
        drive_bit(1'b0); for (int i = 0; i < 8; i++) drive_bit(1'b1);
        drive_bit(1'b1); drive_bit(1'b1);
        chk("R5 fixed zero mismatch", err_parity, 1);
        pulse_rd(1'b1, 1'b1);

        // R6 framing error
        cfg_par_on = 1'b0; cfg_par_fix = 1'b0;
        send(8'h3C, 1'b0, 1'b0);
        chk("R6 framing", err_frame, 1);
        chk("R6 no break", brk_seen, 0);
        pulse_rd(1'b1, 1'b1);
        chk("R11 status clears", {err_frame, err_parity, err_overrun, brk_seen}, 0);

        // R7 break and R8 wait-for-high
        cfg_par_on = 1'b1; cfg_par_even = 1'b0;
        rx_line = 1'b0;
        repeat (BITCLK * 12) @(negedge clk);
        chk("R7 break flag", brk_seen, 1);
        chk("R7 break no frame/parity", {err_frame, err_parity}, 0);
        chk("R7 break byte", rx_byte, 8'h00);
        chk("R7 break avail", rx_avail, 1);
        pulse_rd(1'b1, 1'b1);
        repeat (BITCLK * 12) @(negedge clk);
        chk("R8 no restart while low", rx_avail, 0);
        rx_line = 1'b1;
        repeat (BITCLK) @(negedge clk);
        send(8'h5A, 1'b0, 1'b1);
        chk("R8 resumes after high", rx_byte, 8'h5A);
        pulse_rd(1'b1, 1'b1);

        // R9 overrun
        cfg_par_on = 1'b0;
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        chk("R9 overrun flag", err_overrun, 1);
        chk("R9 keeps old byte", rx_byte, 8'h11);
        chk("R9 still avail", rx_avail, 1);
        pulse_rd(1'b0, 1'b1);
        chk("R11 overrun cleared", err_overrun, 0);
        chk("R10 avail kept by status read", rx_avail, 1);
        pulse_rd(1'b1, 1'b0);
        chk("R10 avail cleared", rx_avail, 0);

        // R11 set wins over clear in the same cycle
        cfg_par_on = 1'b1; cfg_par_even = 1'b1;
        rd_status = 1'b1;
        fork
            send(8'h0F, 1'b1, 1'b1);
            begin
                hi_cnt = 0;
                repeat (BITCLK * 11) begin
                    @(negedge clk);
                    if (err_parity) hi_cnt++;
                end
            end
        join
        rd_status = 1'b0;
        chk("R11 set wins one cycle", hi_cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule